// File: doc/BRIEF.md
# Linked-Reservation Monitor for Atomic Word Updates

This block lets one or two requesters perform atomic read-modify-write sequences on a shared, byte-addressed word memory. A requester first issues a linked read. The monitor then holds a reservation for that requester on the word that was read. Later the requester issues a conditional store. The store is allowed to commit only if nothing has written that word since the linked read.

The core reports every memory write that does not come from the monitor on a snoop port. That includes ordinary stores and stores from other agents. The monitor answers each conditional store one clock later with a response strobe and an ok flag. The core writes 1 (success) or 0 (failure) into the store's register. The core performs the memory write only when the ok flag is 1.

Each requester has its own reservation slot, so each requester holds at most one reservation at a time. Matching is done on word addresses. Cache coherence and bus arbitration stay outside the block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation exists. A conditional store issued before any linked read returns ok = 0, and `sc_resp_valid` is 0 while reset is held.
- R2: A linked read followed by a conditional store from the same requester to the same word returns ok = 1. `sc_resp_valid` and `sc_resp_ok` appear in the cycle after the store is presented.
- R3: Matching uses the word address only. Address bits [1:0] are ignored for linked reads, conditional stores and snooped writes.
- R4: A snooped write to the reserved word clears the reservation, so the next conditional store fails. A snooped write to any other word leaves the reservation intact.
- R5: A conditional store clears its own requester's reservation whether it succeeds or fails. A second store without a new linked read returns ok = 0.
- R6: A conditional store to a word other than the reserved one returns ok = 0.
- R7: If a conditional store and a snooped write to the same word arrive in the same cycle, the snooped write wins and the store returns ok = 0.
- R8: Each requester holds an independent reservation. A successful conditional store by one requester clears any other requester's reservation on the same word. Requester ids are encoded 0 and 1.
- R9: A new linked read from a requester replaces that requester's previous reservation. A store to the old word then fails, and a store to the new word succeeds.
- R10: A linked read that arrives in the same cycle as a snooped write to the same word leaves no reservation.
- R11: `sc_resp_valid` is high for exactly one cycle per conditional store, and `sc_resp_ok` is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Linked read presented this cycle |
| ll_id | input | REQ_W | Requester issuing the linked read |
| ll_addr | input | ADDR_W | Byte address of the linked read |
| sc_valid | input | 1 | Conditional store presented this cycle |
| sc_id | input | REQ_W | Requester issuing the conditional store |
| sc_addr | input | ADDR_W | Byte address of the conditional store |
| snp_valid | input | 1 | Some other write to memory this cycle |
| snp_addr | input | ADDR_W | Byte address of that write |
| sc_resp_valid | output | 1 | Store outcome available (one cycle after the store) |
| sc_resp_ok | output | 1 | 1 = store commits, 0 = store failed |

## Verification
The bench builds the monitor with two requesters and a 16-bit address. With two requesters, independent reservations are reachable, and so is cross-requester invalidation by a successful store. The 16-bit address leaves room for byte offsets that differ only in bits [1:0]. The same-cycle races are driven directly: store against snoop, and linked read against snoop.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   localparam int unsigned BYTE_OFF_W = 2;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
   parameter int unsigned WORD_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ll_mine,
   input  logic [WORD_W-1:0] ll_word,
   input  logic              sc_mine,
   input  logic [WORD_W-1:0] sc_word,
   input  logic              snp_valid,
   input  logic [WORD_W-1:0] snp_word,
   input  logic              peer_ok,
   output logic              sc_ok
);
   logic              resv_valid;
   logic [WORD_W-1:0] resv_word;
   logic              snp_kills;
   logic              peer_kills;
   logic              snp_blocks_ll;
   logic              peer_blocks_ll;

   assign snp_kills      = snp_valid && (snp_word == resv_word);
   assign peer_kills     = peer_ok && (sc_word == resv_word);
   assign snp_blocks_ll  = snp_valid && (snp_word == ll_word);
   assign peer_blocks_ll = peer_ok && (sc_word == ll_word);

   // snooped write in the same cycle defeats the store
   assign sc_ok = sc_mine && resv_valid && (sc_word == resv_word) &&
                  !(snp_valid && (snp_word == sc_word));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resv_valid <= 1'b0;
         resv_word  <= '0;
      end else if (ll_mine) begin
         resv_valid <= !(snp_blocks_ll || peer_blocks_ll);
         resv_word  <= ll_word;
      end else if (sc_mine || snp_kills || peer_kills) begin
         resv_valid <= 1'b0;
      end
   end

   // R4
   snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_valid && snp_kills && !ll_mine) |=> !resv_valid);
   // R5
   sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_mine && !ll_mine) |=> !resv_valid);
   // R7
   race_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && sc_mine && (snp_word == sc_word)) |-> !sc_ok);
endmodule

// File: rtl/llsc_resp_stage.sv
module llsc_resp_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic sc_valid,
   input  logic any_ok,
   output logic resp_valid,
   output logic resp_ok
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_ok    <= 1'b0;
      end else begin
         resp_valid <= sc_valid;
         resp_ok    <= sc_valid && any_ok;
      end
   end

   // R11
   ok_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ok |-> resp_valid);
   // R11
   valid_follows_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_valid |=> !resp_valid);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int unsigned NUM_REQ = 2,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned REQ_W  = id_width(NUM_REQ),
   localparam int unsigned WORD_W = ADDR_W - BYTE_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ll_valid,
   input  logic [REQ_W-1:0]  ll_id,
   input  logic [ADDR_W-1:0] ll_addr,
   input  logic              sc_valid,
   input  logic [REQ_W-1:0]  sc_id,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              sc_resp_valid,
   output logic              sc_resp_ok
);
   initial begin
      if (NUM_REQ < 1 || NUM_REQ > 2)
         $error("llsc_monitor: NUM_REQ must be 1 or 2");
      if (ADDR_W <= BYTE_OFF_W)
         $error("llsc_monitor: ADDR_W too small");
   end

   logic [WORD_W-1:0]  ll_word, sc_word, snp_word;
   logic [NUM_REQ-1:0] ok_vec;
   logic               any_ok;

   assign ll_word  = ll_addr[ADDR_W-1:BYTE_OFF_W];
   assign sc_word  = sc_addr[ADDR_W-1:BYTE_OFF_W];
   assign snp_word = snp_addr[ADDR_W-1:BYTE_OFF_W];
   assign any_ok   = |ok_vec;

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
      logic ll_mine, sc_mine, peer_ok;
      assign ll_mine = ll_valid && (ll_id == REQ_W'(g));
      assign sc_mine = sc_valid && (sc_id == REQ_W'(g));
      assign peer_ok = any_ok && !sc_mine;
      llsc_resv_slot #(.WORD_W(WORD_W)) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .ll_mine  (ll_mine),
         .ll_word  (ll_word),
         .sc_mine  (sc_mine),
         .sc_word  (sc_word),
         .snp_valid(snp_valid),
         .snp_word (snp_word),
         .peer_ok  (peer_ok),
         .sc_ok    (ok_vec[g])
      );
   end

   llsc_resp_stage resp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sc_valid  (sc_valid),
      .any_ok    (any_ok),
      .resp_valid(sc_resp_valid),
      .resp_ok   (sc_resp_ok)
   );

   // R8
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ok_vec));
   // R2
   ok_only_on_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_ok |-> sc_valid);
endmodule

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
   localparam int unsigned AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ll_valid = 1'b0, sc_valid = 1'b0, snp_valid = 1'b0;
   logic [0:0]    ll_id = '0, sc_id = '0;
   logic [AW-1:0] ll_addr = '0, sc_addr = '0, snp_addr = '0;
   logic          sc_resp_valid, sc_resp_ok;
   int            n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   llsc_monitor #(.NUM_REQ(2), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ll_valid(ll_valid), .ll_id(ll_id), .ll_addr(ll_addr),
      .sc_valid(sc_valid), .sc_id(sc_id), .sc_addr(sc_addr),
      .snp_valid(snp_valid), .snp_addr(snp_addr),
      .sc_resp_valid(sc_resp_valid), .sc_resp_ok(sc_resp_ok)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   // one clock of stimulus; inputs set after a falling edge, cleared after the next
   task automatic step(input logic l, input int li, input logic [AW-1:0] la,
                       input logic s, input int si, input logic [AW-1:0] sa,
                       input logic w, input logic [AW-1:0] wa);
      ll_valid = l; ll_id = 1'(li); ll_addr = la;
      sc_valid = s; sc_id = 1'(si); sc_addr = sa;
      snp_valid = w; snp_addr = wa;
      @(negedge clk);
      ll_valid = 1'b0; sc_valid = 1'b0; snp_valid = 1'b0;
   endtask

   task automatic ll(input int id, input logic [AW-1:0] a);
      step(1'b1, id, a, 1'b0, 0, '0, 1'b0, '0);
   endtask

   task automatic snoop(input logic [AW-1:0] a);
      step(1'b0, 0, '0, 1'b0, 0, '0, 1'b1, a);
   endtask

   task automatic sc(input int id, input logic [AW-1:0] a, input logic exp, input string req);
      step(1'b0, 0, '0, 1'b1, id, a, 1'b0, '0);
      check(req, sc_resp_valid, 1'b1);
      check(req, sc_resp_ok, exp);
   endtask

   task automatic t_reset;
      check("R1", sc_resp_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      sc(0, 16'h0100, 1'b0, "R1");
   endtask

   task automatic t_basic;
      ll(0, 16'h0200);
      sc(0, 16'h0200, 1'b1, "R2");
      @(negedge clk);
      check("R11", sc_resp_valid, 1'b0);
      check("R11", sc_resp_ok, 1'b0);
   endtask

   task automatic t_granule;
      ll(1, 16'h0301);
      snoop(16'h0307);
      sc(1, 16'h0302, 1'b1, "R3");
      ll(1, 16'h0310);
      snoop(16'h0313);
      sc(1, 16'h0310, 1'b0, "R3");
   endtask

   task automatic t_snoop;
      ll(0, 16'h0400);
      snoop(16'h0404);
      sc(0, 16'h0400, 1'b1, "R4");
      ll(0, 16'h0400);
      snoop(16'h0400);
      sc(0, 16'h0400, 1'b0, "R4");
   endtask

   task automatic t_sc_clears;
      ll(1, 16'h0500);
      sc(1, 16'h0500, 1'b1, "R5");
      sc(1, 16'h0500, 1'b0, "R5");
      ll(1, 16'h0500);
      sc(1, 16'h0504, 1'b0, "R6");
      sc(1, 16'h0500, 1'b0, "R5");
   endtask

   task automatic t_race;
      ll(0, 16'h0600);
      step(1'b0, 0, '0, 1'b1, 0, 16'h0600, 1'b1, 16'h0602);
      check("R7", sc_resp_valid, 1'b1);
      check("R7", sc_resp_ok, 1'b0);
   endtask

   task automatic t_two_req;
      ll(0, 16'h0700);
      ll(1, 16'h0800);
      sc(1, 16'h0800, 1'b1, "R8");
      sc(0, 16'h0700, 1'b1, "R8");
      ll(0, 16'h0900);
      ll(1, 16'h0900);
      sc(0, 16'h0900, 1'b1, "R8");
      sc(1, 16'h0900, 1'b0, "R8");
   endtask

   task automatic t_replace;
      ll(0, 16'h0A00);
      ll(0, 16'h0B00);
      sc(0, 16'h0A00, 1'b0, "R9");
      ll(0, 16'h0A00);
      ll(0, 16'h0B00);
      sc(0, 16'h0B00, 1'b1, "R9");
   endtask

   task automatic t_ll_race;
      step(1'b1, 1, 16'h0C00, 1'b0, 0, '0, 1'b1, 16'h0C01);
      sc(1, 16'h0C00, 1'b0, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_granule();
      t_snoop();
      t_sc_clears();
      t_race();
      t_two_req();
      t_replace();
      t_ll_race();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule